// File: doc/BRIEF.md
# Wormhole Packet Router

This block is a single router node for an on-chip network. A parameter sets the number of ports, from 2 to 7, and the default is five: East, West, North, South and Local, at indices 0 to 4. Every input port has an eight-entry flit queue and a route decoder. The decoder reads the destination identifier from the head flit of each packet and raises a request toward one output. Every output has its own round-robin arbiter. When an arbiter grants an input, it locks that input to the output for the whole packet, and flits then cross a full crossbar.

Packets always have the same length: sixteen 8-bit flits, which is 128 bits. Each input counts the flits it dequeues, so it knows where a packet ends without any tail marker on the wire. Every port, inbound and outbound, uses a valid/ready handshake. A destination identifier that the route table does not map to an existing port is sent to the Local port, so such a packet still drains.

Top module: `wh_router`

## Requirements
- R1: After reset, every `out_valid` bit is low, every `in_ready` bit is high, and each output's round-robin pointer is at input 0.
- R2: A flit is taken on an input only in a cycle where valid and ready are both high. `in_ready` goes low once eight flits are queued on that input. A queued flit is never lost or overwritten.
- R3: Bits [2:0] of a head flit form a destination identifier. This identifier indexes an eight-entry route table, and the default table is the identity (0 selects port 0, 1 selects port 1, and so on). The packet leaves on the port that the table gives.
- R4: When the table entry is not below the port count, the packet leaves on the Local port. Local is the highest port index, which is 4 by default.
- R5: Once an output grants an input, it stays locked to that input until 16 flits have been transferred. All 16 flits leave in their original order, and no flit from another input is mixed in.
- R6: After an output finishes a packet from input w, its next arbitration searches from input w+1, wrapping around after the highest index.
- R7: When several inputs are waiting for the same output right after reset, the lowest-numbered one is served first.
- R8: Packets between different input/output pairs move at the same time, and no input is ever locked by two outputs.
- R9: While `out_valid` is high and `out_ready` is low, the output keeps `out_valid` high and holds `out_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | NPORTS | Flit offered on each input |
| in_data | input | NPORTS*FLIT_W | Input flits; port i uses bits [i*FLIT_W +: FLIT_W] |
| in_ready | output | NPORTS | Input queue has space |
| out_valid | output | NPORTS | Flit presented on each output |
| out_data | output | NPORTS*FLIT_W | Output flits, packed the same way as the inputs |
| out_ready | input | NPORTS | Downstream accepts the flit |

## Verification
The round-robin pointer is the hardest state to reach, because it only changes when a full packet completes and it cannot be seen at the ports. To set it, the stimulus first sends one packet from input 2 alone, which leaves the pointer at 3. Inputs 1 and 3 then request the same output in the same cycle, and input 3 must win, which a fixed-priority arbiter would not do. A full input queue is reached by holding `out_ready` low during a 16-flit packet. The bench then confirms that exactly eight flits were taken, that the stalled head flit stays on the output unchanged, and that all sixteen flits arrive in order once the output is released.

// File: rtl/wh_router_pkg.sv
package wh_router_pkg;
    localparam int unsigned DEST_W = 3;
    localparam int unsigned MAP_N  = 1 << DEST_W;

    typedef enum logic [2:0] {
        DIR_EAST  = 3'd0,
        DIR_WEST  = 3'd1,
        DIR_NORTH = 3'd2,
        DIR_SOUTH = 3'd3,
        DIR_LOCAL = 3'd4
    } dir_e;
endpackage

// File: rtl/wh_inport.sv
module wh_inport
    import wh_router_pkg::*;
#(
    parameter int unsigned NPORTS  = 5,
    parameter int unsigned FLIT_W  = 8,
    parameter int unsigned PKT_LEN = 16,
    parameter int unsigned DEPTH   = 8,
    parameter logic [MAP_N*DEST_W-1:0] ROUTE_MAP = {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0},
    localparam int unsigned PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FLIT_W-1:0] in_data,
    output logic              in_ready,
    input  logic              pop,
    output logic              head_vld,
    output logic [FLIT_W-1:0] head_data,
    output logic [PW-1:0]     req_port,
    output logic              is_last
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned LW = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][FLIT_W-1:0] mem;
        logic [AW-1:0]                wr;
        logic [AW-1:0]                rd;
        logic [CW-1:0]                cnt;
        logic [LW-1:0]                pos;
        logic [PW-1:0]                route;
    } inport_t;

    inport_t state_d, state_q;
    logic [DEST_W-1:0] dest_id;
    logic [DEST_W-1:0] entry;
    logic [PW-1:0]     decoded;
    logic              push, deq;

    always_comb begin
        state_d   = state_q;
        in_ready  = (state_q.cnt != CW'(DEPTH));
        head_vld  = (state_q.cnt != '0);
        head_data = state_q.mem[state_q.rd];
        dest_id   = head_data[DEST_W-1:0];
        entry     = ROUTE_MAP[dest_id*DEST_W +: DEST_W];
        decoded   = (32'(entry) >= NPORTS) ? PW'(NPORTS - 1) : entry[PW-1:0];
        req_port  = (state_q.pos == '0) ? decoded : state_q.route;
        is_last   = (state_q.pos == LW'(PKT_LEN - 1));
        push      = in_valid && in_ready;
        deq       = pop && head_vld;
        if (push) begin
            state_d.mem[state_q.wr] = in_data;
            state_d.wr = (state_q.wr == AW'(DEPTH - 1)) ? '0 : state_q.wr + 1'b1;
        end
        if (deq) begin
            state_d.rd  = (state_q.rd == AW'(DEPTH - 1)) ? '0 : state_q.rd + 1'b1;
            state_d.pos = is_last ? '0 : state_q.pos + 1'b1;
            if (state_q.pos == '0) state_d.route = decoded;
        end
        state_d.cnt = state_q.cnt + CW'(push) - CW'(deq);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R2: the queue never holds more than its depth
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.cnt <= CW'(DEPTH));

    // R5: the flit after a packet's tail is treated as a new head
    p_tail_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && head_vld && is_last) |=> (state_q.pos == '0));
endmodule

// File: rtl/wh_rrarb.sv
module wh_rrarb #(
    parameter int unsigned NPORTS = 5,
    localparam int unsigned PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] req,
    input  logic              fire,
    input  logic              last,
    output logic              busy,
    output logic [PW-1:0]     owner
);
    typedef struct packed {
        logic          busy;
        logic [PW-1:0] owner;
        logic [PW-1:0] ptr;
    } arb_t;

    arb_t          state_d, state_q;
    logic          found;
    logic [PW-1:0] pick;

    always_comb begin
        state_d = state_q;
        found   = 1'b0;
        pick    = '0;
        for (int k = 0; k < NPORTS; k++) begin
            int idx;
            idx = (int'(state_q.ptr) + k) % NPORTS;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = PW'(idx);
            end
        end
        if (!state_q.busy && found) begin
            state_d.busy  = 1'b1;
            state_d.owner = pick;
        end else if (state_q.busy && fire && last) begin
            state_d.busy = 1'b0;
            state_d.ptr  = (state_q.owner == PW'(NPORTS - 1)) ? '0 : state_q.owner + 1'b1;
        end
    end

    assign busy  = state_q.busy;
    assign owner = state_q.owner;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R5: an output stays locked to its owner until the tail flit leaves
    p_hold_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.busy && !(fire && last)) |=> (state_q.busy && $stable(state_q.owner)));

    // R6: once a packet is done, the search starts after the input that sent it
    p_ptr_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.busy && fire && last) |=> (!state_q.busy &&
            state_q.ptr == (($past(state_q.owner) == PW'(NPORTS - 1)) ? '0 : $past(state_q.owner) + 1'b1)));
endmodule

// File: rtl/wh_router.sv
module wh_router
    import wh_router_pkg::*;
#(
    parameter int unsigned NPORTS    = 5,
    parameter int unsigned FLIT_W    = 8,
    parameter int unsigned PKT_LEN   = 16,
    parameter int unsigned BUF_DEPTH = 8,
    parameter logic [MAP_N*DEST_W-1:0] ROUTE_MAP = {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORTS-1:0]        in_valid,
    input  logic [NPORTS*FLIT_W-1:0] in_data,
    output logic [NPORTS-1:0]        in_ready,
    output logic [NPORTS-1:0]        out_valid,
    output logic [NPORTS*FLIT_W-1:0] out_data,
    input  logic [NPORTS-1:0]        out_ready
);
    localparam int unsigned PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    logic [NPORTS-1:0] hv, lst, pop, busy, fire, lastv;
    logic [FLIT_W-1:0] hd   [NPORTS];
    logic [PW-1:0]     rp   [NPORTS];
    logic [PW-1:0]     own  [NPORTS];
    logic [NPORTS-1:0] reqm [NPORTS];
    logic [NPORTS-1:0] held [NPORTS];

    for (genvar i = 0; i < NPORTS; i++) begin : g_in
        wh_inport #(
            .NPORTS(NPORTS), .FLIT_W(FLIT_W), .PKT_LEN(PKT_LEN),
            .DEPTH(BUF_DEPTH), .ROUTE_MAP(ROUTE_MAP)
        ) u_in (
            .clk(clk), .rst_n(rst_n),
            .in_valid(in_valid[i]), .in_data(in_data[i*FLIT_W +: FLIT_W]),
            .in_ready(in_ready[i]), .pop(pop[i]),
            .head_vld(hv[i]), .head_data(hd[i]),
            .req_port(rp[i]), .is_last(lst[i])
        );
    end

    for (genvar j = 0; j < NPORTS; j++) begin : g_out
        wh_rrarb #(.NPORTS(NPORTS)) u_arb (
            .clk(clk), .rst_n(rst_n),
            .req(reqm[j]), .fire(fire[j]), .last(lastv[j]),
            .busy(busy[j]), .owner(own[j])
        );
    end

    // crossbar: request matrix, output mux and dequeue
    always_comb begin
        pop = '0;
        for (int j = 0; j < NPORTS; j++) begin
            for (int i = 0; i < NPORTS; i++) begin
                reqm[j][i] = hv[i] && (rp[i] == PW'(j));
                held[i][j] = busy[j] && (own[j] == PW'(i));
            end
            out_valid[j]                  = busy[j] && hv[own[j]];
            out_data[j*FLIT_W +: FLIT_W]  = hd[own[j]];
            fire[j]                       = out_valid[j] && out_ready[j];
            lastv[j]                      = lst[own[j]];
            if (fire[j]) pop[own[j]] = 1'b1;
        end
    end

    for (genvar k = 0; k < NPORTS; k++) begin : g_chk
        // R9: a stalled output neither drops nor changes its flit
        p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[k] && !out_ready[k]) |=>
                (out_valid[k] && $stable(out_data[k*FLIT_W +: FLIT_W])));
        // R8: no input is locked by two outputs at once
        p_one_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(held[k]));
    end
endmodule

// File: tb/sim_wh_router.sv
module sim_wh_router;
    localparam int NP = 5;
    localparam int FW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     iv = '0;
    logic [NP*FW-1:0]  id = '0;
    logic [NP-1:0]     ir;
    logic [NP-1:0]     ov;
    logic [NP*FW-1:0]  od;
    logic [NP-1:0]     ordy = '1;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] got [NP][64];
    int gn [NP];
    int acc [NP];

    always #5 clk = ~clk;

    wh_router u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(iv), .in_data(id), .in_ready(ir),
        .out_valid(ov), .out_data(od), .out_ready(ordy)
    );

    // an output transfer happens at the next rising edge if valid and ready hold here
    always @(negedge clk) begin
        if (rst_n) begin
            for (int j = 0; j < NP; j++) begin
                if (ov[j] && ordy[j]) begin
                    if (gn[j] < 64) got[j][gn[j]] = od[j*FW +: FW];
                    gn[j]++;
                end
            end
        end
    end

    function automatic logic [7:0] mk_flit(int s, int d, int k);
        if (k == 0) return {3'(s), 2'b00, 3'(d)};
        return {3'(s), 1'b0, 4'(k)};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_pkt(int port, int start, int s, int d, string req);
        int bad;
        int act;
        int exp;
        bad = -1;
        act = 0;
        exp = 0;
        for (int k = 0; k < 16; k++) begin
            if (bad < 0 && got[port][start + k] !== mk_flit(s, d, k)) begin
                bad = k;
                act = int'(got[port][start + k]);
                exp = int'(mk_flit(s, d, k));
            end
        end
        check(bad < 0, req, act, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        iv = '0;
        ordy = '1;
        for (int j = 0; j < NP; j++) begin
            gn[j] = 0;
            acc[j] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic send_pkt(int s, int d);
        bit ok;
        @(posedge clk);
        #1;
        for (int k = 0; k < 16; k++) begin
            iv[s] = 1'b1;
            id[s*FW +: FW] = mk_flit(s, d, k);
            do begin
                @(negedge clk);
                ok = ir[s];
                @(posedge clk);
                #1;
            end while (!ok);
            acc[s]++;
        end
        iv[s] = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        check(ov == '0, "R1 out_valid low", int'(ov), 0);
        check(ir == '1, "R1 in_ready high", int'(ir), 31);
    endtask

    task automatic t_single_route();
        do_reset();
        send_pkt(1, 3);
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(gn[3] == 16, "R3 flit count on South", gn[3], 16);
        chk_pkt(3, 0, 1, 3, "R3 packet content");
        check(gn[0] + gn[1] + gn[2] + gn[4] == 0, "R3 no stray flits", gn[0] + gn[1] + gn[2] + gn[4], 0);
    endtask

    task automatic t_invalid_dest();
        do_reset();
        send_pkt(0, 6);
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(gn[4] == 16, "R4 unmapped id to Local", gn[4], 16);
        chk_pkt(4, 0, 0, 6, "R4 Local content");
    endtask

    task automatic t_backpressure();
        do_reset();
        ordy[0] = 1'b0;
        fork
            send_pkt(1, 0);
            begin
                repeat (25) @(posedge clk);
                @(negedge clk);
                check(acc[1] == 8, "R2 flits taken while stalled", acc[1], 8);
                check(ir[1] == 1'b0, "R2 in_ready low when full", int'(ir[1]), 0);
                check(gn[0] == 0, "R2 nothing leaves while stalled", gn[0], 0);
                check(ov[0] == 1'b1, "R9 out_valid held", int'(ov[0]), 1);
                check(od[0 +: FW] == mk_flit(1, 0, 0), "R9 head flit held", int'(od[0 +: FW]), int'(mk_flit(1, 0, 0)));
                @(posedge clk);
                #1 ordy[0] = 1'b1;
            end
        join
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(gn[0] == 16, "R2 all flits delivered", gn[0], 16);
        chk_pkt(0, 0, 1, 0, "R2 order kept after stall");
    endtask

    task automatic t_reset_priority();
        do_reset();
        fork
            send_pkt(3, 0);
            send_pkt(1, 0);
        join
        repeat (30) @(posedge clk);
        @(negedge clk);
        check(gn[0] == 32, "R7 both packets delivered", gn[0], 32);
        chk_pkt(0, 0, 1, 0, "R7 lowest index first");
        chk_pkt(0, 16, 3, 0, "R5 second packet whole");
    endtask

    task automatic t_round_robin();
        do_reset();
        send_pkt(2, 0);
        repeat (10) @(posedge clk);
        fork
            send_pkt(1, 0);
            send_pkt(3, 0);
        join
        repeat (30) @(posedge clk);
        @(negedge clk);
        check(gn[0] == 48, "R6 three packets delivered", gn[0], 48);
        chk_pkt(0, 16, 3, 0, "R6 input after last winner served first");
        chk_pkt(0, 32, 1, 0, "R5 no interleave for wrapped winner");
    endtask

    task automatic t_parallel();
        do_reset();
        fork
            send_pkt(0, 2);
            send_pkt(3, 1);
        join
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(gn[2] == 16 && gn[1] == 16, "R8 both paths done together", gn[2] + gn[1], 32);
        chk_pkt(2, 0, 0, 2, "R8 East to North content");
        chk_pkt(1, 0, 3, 1, "R8 South to West content");
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_single_route();
        t_invalid_dest();
        t_backpressure();
        t_reset_priority();
        t_round_robin();
        t_parallel();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule